// File: doc/BRIEF.md
# Two-Slot SPI Receive Holding Stage

This block sits between the deserializer of an SPI engine and whatever consumes the received characters. It can hold up to two characters. One sits in a visible register that the reader always sees. The other sits in a hidden backing register. An internal pointer records which slot the next arrival goes to. Each arrival strobe comes with the character that was just assembled. A read strobe consumes the visible character. When another character is waiting, the read promotes it into the visible slot.

When a third character arrives while two are still unread, the oldest one is thrown away. The two newest are kept, and a sticky overrun flag is raised. Taking the enable low empties the stage and clears the flag.

Top module: `spi_rx_hold`

## Requirements
- R1: After reset, and after `en` has been low, the stage is empty: `rx_ready` is 0 and `ovf_flag` is 0.
- R2: When a character arrives with the stage empty, it becomes visible on `rd_data` in the next cycle and `rx_ready` rises.
- R3: A read while exactly one character is held empties the stage, and `rx_ready` falls in the next cycle.
- R4: A second arrival before any read goes to the hidden slot. `rd_data` keeps showing the first character.
- R5: A read while two characters are held consumes the older one, which `rd_data` shows during the strobe cycle. The newer one is visible after the read. A following read empties the stage.
- R6: An arrival while two characters are held discards the oldest. The stage then holds the former hidden character as visible and the new character as hidden.
- R7: The discard case of R6 sets `ovf_flag`, which stays high until `ovf_clr` is pulsed. When a discard and `ovf_clr` fall in the same cycle, the flag stays set.
- R8: A read and an arrival in the same cycle are handled read first, then arrival. With one held, the new character becomes visible and one is held. With two held, no discard happens and `ovf_flag` is unchanged.
- R9: While `en` is low, arrival and read strobes are ignored, and `rx_ready` stays 0.
- R10: A read strobe while the stage is empty has no effect: `rx_ready` stays 0 and `ovf_flag` is unchanged.
- R11: `rx_ready` is high exactly when at least one unread character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable. Low empties the stage and clears the flag |
| rx_strobe | input | 1 | A received character is presented |
| rx_char | input | DATA_W | Character from the shift register |
| rd_strobe | input | 1 | Consume the visible character |
| ovf_clr | input | 1 | Clear the overrun flag |
| rd_data | output | DATA_W | Visible character |
| rx_ready | output | 1 | At least one unread character is held |
| ovf_flag | output | 1 | Sticky overrun indication |

## Verification
The pointer logic is driven by several fill patterns:
- single arrival then read;
- two arrivals drained by two reads;
- three and four arrivals with no read;
- reads and arrivals that coincide at each fill level.

Single and double fills separate the visible-slot path from the hidden-slot path. The over-filled patterns show whether the oldest or the newest character is the one dropped. The coincident cases show whether the read is ordered before the arrival: a wrong order either loses a character or raises a false overrun. Reads on an empty stage, strobes while disabled, and a clear that coincides with a discard probe the edges of the flag and occupancy logic.

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rd_strobe,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              ovf_flag
);

  logic [1:0]        cnt, cnt_n, mid_cnt;
  logic [DATA_W-1:0] vis, hid, vis_n, hid_n, mid_vis;
  logic              ovf_n, take_rd, drop;

  assign take_rd = en && rd_strobe && (cnt != 2'd0);
  assign mid_cnt = take_rd ? cnt - 2'd1 : cnt;
  assign mid_vis = (take_rd && cnt == 2'd2) ? hid : vis;
  assign drop    = en && rx_strobe && (mid_cnt == 2'd2);

  always_comb begin
    cnt_n = mid_cnt;
    vis_n = mid_vis;
    hid_n = hid;
    if (en && rx_strobe) begin
      case (mid_cnt)
        2'd0: begin vis_n = rx_char; cnt_n = 2'd1; end
        2'd1: begin hid_n = rx_char; cnt_n = 2'd2; end
        default: begin vis_n = hid; hid_n = rx_char; cnt_n = 2'd2; end
      endcase
    end
    if (drop)         ovf_n = 1'b1;
    else if (ovf_clr) ovf_n = 1'b0;
    else              ovf_n = ovf_flag;
    if (!en) begin
      cnt_n = 2'd0;
      vis_n = '0;
      hid_n = '0;
      ovf_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= 2'd0;
      vis      <= '0;
      hid      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      vis      <= vis_n;
      hid      <= hid_n;
      ovf_flag <= ovf_n;
    end
  end

  assign rd_data  = vis;
  assign rx_ready = (cnt != 2'd0);

  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  assert_idle_after_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rx_ready && !ovf_flag);

  assert_first_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_strobe && !rd_strobe && !rx_ready) |=> rx_ready && rd_data == $past(rx_char));

  assert_promote_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_strobe && !rx_strobe && cnt == 2'd2) |=> rd_data == $past(hid) && cnt == 2'd1);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag && cnt == 2'd2 && rd_data == $past(hid));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_strobe && !rx_strobe && !ovf_clr && !rx_ready) |=> !rx_ready && $stable(ovf_flag));

endmodule

// File: tb/sim_spi_rx_hold.sv
module sim_spi_rx_hold;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic rx_strobe = 1'b0, rd_strobe = 1'b0, ovf_clr = 1'b0;
  logic [W-1:0] rx_char = '0;
  logic [W-1:0] rd_data;
  logic rx_ready, ovf_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_rx_hold #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_strobe(rx_strobe), .rx_char(rx_char),
    .rd_strobe(rd_strobe), .ovf_clr(ovf_clr), .rd_data(rd_data),
    .rx_ready(rx_ready), .ovf_flag(ovf_flag));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; returns at the following falling edge
  task automatic cyc(input bit rx, input logic [W-1:0] d, input bit rd, input bit clr);
    @(negedge clk);
    rx_strobe = rx; rx_char = d; rd_strobe = rd; ovf_clr = clr;
    @(negedge clk);
    rx_strobe = 0; rd_strobe = 0; ovf_clr = 0;
  endtask

  task automatic restart();
    @(negedge clk); en = 0;
    @(negedge clk); en = 1;
  endtask

  task automatic t_reset();
    chk("R1 ready", rx_ready, 0);
    chk("R1 ovf", ovf_flag, 0);
  endtask

  task automatic t_single();
    restart();
    cyc(1, 8'h3C, 0, 0);
    chk("R2 ready", rx_ready, 1);
    chk("R2 data", rd_data, 8'h3C);
    cyc(0, 0, 1, 0);
    chk("R3 ready", rx_ready, 0);
  endtask

  task automatic t_double();
    restart();
    cyc(1, 8'h11, 0, 0);
    cyc(1, 8'h22, 0, 0);
    chk("R4 data", rd_data, 8'h11);
    chk("R4 ready", rx_ready, 1);
    @(negedge clk); rd_strobe = 1; #1;
    chk("R5 older during strobe", rd_data, 8'h11);
    @(negedge clk); rd_strobe = 0;
    chk("R5 newer visible", rd_data, 8'h22);
    chk("R5 ready", rx_ready, 1);
    cyc(0, 0, 1, 0);
    chk("R5 empty", rx_ready, 0);
    chk("R5 no ovf", ovf_flag, 0);
  endtask

  task automatic t_overrun();
    restart();
    cyc(1, 8'hA1, 0, 0);
    cyc(1, 8'hA2, 0, 0);
    cyc(1, 8'hA3, 0, 0);
    chk("R6 oldest dropped", rd_data, 8'hA2);
    chk("R7 ovf set", ovf_flag, 1);
    cyc(1, 8'hA4, 0, 0);
    chk("R6 second drop", rd_data, 8'hA3);
    cyc(0, 0, 1, 0);
    chk("R6 newest kept", rd_data, 8'hA4);
    chk("R7 sticky", ovf_flag, 1);
    cyc(0, 0, 1, 0);
    chk("R11 empty", rx_ready, 0);
    chk("R7 still sticky", ovf_flag, 1);
    cyc(0, 0, 0, 1);
    chk("R7 cleared", ovf_flag, 0);
    cyc(1, 8'hB1, 0, 0);
    cyc(1, 8'hB2, 0, 0);
    cyc(1, 8'hB3, 0, 1);
    chk("R7 set beats clear", ovf_flag, 1);
  endtask

  task automatic t_simul();
    restart();
    cyc(1, 8'h55, 1, 0);
    chk("R8 empty arrival", rd_data, 8'h55);
    chk("R8 empty ready", rx_ready, 1);
    cyc(1, 8'h66, 1, 0);
    chk("R8 one held data", rd_data, 8'h66);
    cyc(0, 0, 1, 0);
    chk("R8 one held count", rx_ready, 0);
    cyc(1, 8'h71, 0, 0);
    cyc(1, 8'h72, 0, 0);
    cyc(1, 8'h73, 1, 0);
    chk("R8 two held data", rd_data, 8'h72);
    chk("R8 no ovf", ovf_flag, 0);
    cyc(0, 0, 1, 0);
    chk("R8 hidden kept", rd_data, 8'h73);
    chk("R8 still one", rx_ready, 1);
  endtask

  task automatic t_empty_read();
    restart();
    cyc(0, 0, 1, 0);
    chk("R10 ready", rx_ready, 0);
    chk("R10 ovf", ovf_flag, 0);
    cyc(1, 8'h99, 0, 0);
    chk("R10 later arrival visible", rd_data, 8'h99);
  endtask

  task automatic t_disable();
    restart();
    cyc(1, 8'hC1, 0, 0);
    cyc(1, 8'hC2, 0, 0);
    cyc(1, 8'hC3, 0, 0);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk("R1 disable empties", rx_ready, 0);
    chk("R1 disable clears ovf", ovf_flag, 0);
    cyc(1, 8'hD0, 0, 0);
    chk("R9 arrival ignored", rx_ready, 0);
    @(negedge clk); en = 1;
    @(negedge clk);
    chk("R9 still empty", rx_ready, 0);
    cyc(1, 8'hE5, 0, 0);
    chk("R9 fresh start", rd_data, 8'hE5);
    cyc(1, 8'hE6, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R9 pointer restarted", rd_data, 8'hE6);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_double();
    t_overrun();
    t_simul();
    t_empty_read();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule